// File: doc/BRIEF.md
# Zero-Idiom Eliminating Register Renamer

This block renames a group of up to four micro-ops per clock and removes from the execution path the ones whose result needs no computation. A subtract or an exclusive-or that names the same register as both sources always yields zero, whatever that register held. Such an op is given a fresh physical register, marked ready and holding zero, and is reported complete at rename without ever being dispatched. No-operation micro-ops are completed at rename in the same way and take no register at all.

Every op that writes a destination takes the next free physical tag, in lane order, from a window of tags offered by the free list. A later op in the group that reads a register written earlier in the same group sees the new tag, not the stale one in the map. If the free list offers fewer tags than the group needs, the whole group stalls: nothing is dispatched, completed, popped or written to the map.

Top module: `zidiom_rename`

## Requirements
- R1: A valid op with opcode SUB (2'b01) and equal source registers is eliminated: dispatch_valid low, complete_valid high for that lane in the same cycle.
- R2: A valid op with opcode XOR (2'b10) and equal source registers is eliminated in the same way as R1.
- R3: A valid NOP (opcode 2'b11) has dispatch_valid low and complete_valid high, takes no free tag and leaves the map unchanged; a group of only NOPs is accepted even with no free tags.
- R4: An eliminated zeroing op receives a fresh destination tag with out_dst_zero_rdy high; a dispatched op has out_dst_zero_rdy low, dispatch_valid high and complete_valid low.
- R5: Four zeroing ops in one group are all eliminated in that cycle and fl_pop equals 4.
- R6: A source register written by an earlier lane of the same group is renamed to the tag that the latest such earlier lane received.
- R7: When the number of destination-writing ops exceeds fl_avail, grp_stall is high, all dispatch and completion bits are low, fl_pop is 0, and the map is not updated.
- R8: The k-th destination-writing lane (counting from lane 0) receives free-list slot k of fl_tags (slot k at bits [k*PW +: PW]), and fl_pop equals the number of such lanes.
- R9: After reset architectural register r maps to physical tag r, and invalid lanes assert neither dispatch_valid nor complete_valid.
- R10: SUB or XOR with differing sources, and ALU (2'b00) even with equal sources, are ordinary ops that are dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | LANES | Lane holds a micro-op |
| in_op | input | 2*LANES | Opcode per lane: 00 ALU, 01 SUB, 10 XOR, 11 NOP |
| in_src_a | input | AW*LANES | First source architectural register per lane |
| in_src_b | input | AW*LANES | Second source architectural register per lane |
| in_dst | input | AW*LANES | Destination architectural register per lane |
| fl_avail | input | CW | Number of usable tags in fl_tags |
| fl_tags | input | PW*LANES | Free physical tags, slot 0 first |
| fl_pop | output | CW | Tags consumed this cycle |
| grp_stall | output | 1 | Group held for lack of free tags |
| dispatch_valid | output | LANES | Lane sent to execution |
| complete_valid | output | LANES | Lane completed at rename |
| out_src_a_tag | output | PW*LANES | Renamed first source per lane |
| out_src_b_tag | output | PW*LANES | Renamed second source per lane |
| out_dst_tag | output | PW*LANES | New destination tag per lane (0 if none) |
| out_dst_zero_rdy | output | LANES | Destination tag holds zero and is ready |

## Verification
Groups mixing zeroing SUB and XOR with ordinary ops that share or differ in sources separate the idiom test from the opcode test, and an ALU op with equal sources rules out a check on sources alone. Groups with NOPs between writers show whether tags are taken in lane order and skipped by non-writers. Groups where a register is written twice and then read separate a correct latest-writer bypass from a first-writer or map-only lookup. A group short of tags followed by a group reading the same registers shows whether any partial update leaked into the map, and a long pseudo-random run compares every lane against a sequential model.

// File: rtl/zi_pkg.sv
package zi_pkg;

   typedef enum logic [1:0] {
      OP_ALU = 2'b00,
      OP_SUB = 2'b01,
      OP_XOR = 2'b10,
      OP_NOP = 2'b11
   } zi_op_e;

   typedef struct packed {
      logic alloc;   // writes a destination, takes a tag
      logic zero;    // zeroing idiom
      logic elim;    // completes at rename
   } zi_cls_t;

endpackage

// File: rtl/zi_detect.sv
module zi_detect
   import zi_pkg::*;
#(
   parameter int AW     = 4,
   parameter bit XOR_EN = 1'b1
)(
   input  logic          vld,
   input  logic [1:0]    op,
   input  logic [AW-1:0] src_a,
   input  logic [AW-1:0] src_b,
   output zi_cls_t       cls
);
   logic same_src;
   logic zop;
   logic is_nop;

   assign same_src = (src_a == src_b);
   assign is_nop   = (op == OP_NOP);

   generate
      if (XOR_EN) begin : g_sub_xor
         assign zop = (op == OP_SUB) || (op == OP_XOR);
      end else begin : g_sub_only
         assign zop = (op == OP_SUB);
      end
   endgenerate

   always_comb begin
      cls.zero  = vld && zop && same_src;
      cls.alloc = vld && !is_nop;
      cls.elim  = vld && ((zop && same_src) || is_nop);
   end
endmodule

// File: rtl/zi_alloc.sv
module zi_alloc #(
   parameter int LANES = 4,
   parameter int PW    = 6,
   parameter int CW    = 3
)(
   input  logic                clk,
   input  logic                rst,
   input  logic [LANES-1:0]    alloc,
   input  logic [CW-1:0]       fl_avail,
   input  logic [PW*LANES-1:0] fl_tags,
   output logic [PW*LANES-1:0] lane_tag,
   output logic [CW-1:0]       need,
   output logic                stall
);
   logic [CW-1:0] cnt;

   always_comb begin
      cnt      = '0;
      lane_tag = '0;
      for (int i = 0; i < LANES; i++) begin
         if (alloc[i]) begin
            lane_tag[i*PW +: PW] = fl_tags[int'(cnt)*PW +: PW];
            cnt = cnt + CW'(1);
         end
      end
      need  = cnt;
      stall = (cnt > fl_avail);
   end

   // R8
   need_bound_chk: assert property (@(posedge clk) disable iff (rst)
      int'(need) <= LANES);

   // R8
   need_count_chk: assert property (@(posedge clk) disable iff (rst)
      int'(need) == $countones(alloc));
endmodule

// File: rtl/zi_maptable.sv
module zi_maptable #(
   parameter int LANES     = 4,
   parameter int ARCH_REGS = 16,
   parameter int PHYS_REGS = 64,
   parameter int AW        = $clog2(ARCH_REGS),
   parameter int PW        = $clog2(PHYS_REGS)
)(
   input  logic                clk,
   input  logic                rst,
   input  logic [LANES-1:0]    we,
   input  logic [AW*LANES-1:0] dst,
   input  logic [PW*LANES-1:0] new_tag,
   input  logic [AW*LANES-1:0] src_a,
   input  logic [AW*LANES-1:0] src_b,
   output logic [PW*LANES-1:0] tag_a,
   output logic [PW*LANES-1:0] tag_b
);
   logic [PW-1:0]           map_q [ARCH_REGS];
   logic [PW*ARCH_REGS-1:0] map_flat;

   always_comb begin
      for (int r = 0; r < ARCH_REGS; r++) map_flat[r*PW +: PW] = map_q[r];
   end

   // lookup with forwarding from earlier lanes of the same group
   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         tag_a[i*PW +: PW] = map_q[src_a[i*AW +: AW]];
         tag_b[i*PW +: PW] = map_q[src_b[i*AW +: AW]];
         for (int j = 0; j < i; j++) begin
            if (we[j] && dst[j*AW +: AW] == src_a[i*AW +: AW])
               tag_a[i*PW +: PW] = new_tag[j*PW +: PW];
            if (we[j] && dst[j*AW +: AW] == src_b[i*AW +: AW])
               tag_b[i*PW +: PW] = new_tag[j*PW +: PW];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int r = 0; r < ARCH_REGS; r++) map_q[r] <= PW'(r);
      end else begin
         for (int i = 0; i < LANES; i++) begin
            if (we[i]) map_q[dst[i*AW +: AW]] <= new_tag[i*PW +: PW];
         end
      end
   end

   // R7
   map_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (we == '0) |=> $stable(map_flat));
endmodule

// File: rtl/zidiom_rename.sv
module zidiom_rename
   import zi_pkg::*;
#(
   parameter int LANES       = 4,
   parameter int ARCH_REGS   = 16,
   parameter int PHYS_REGS   = 64,
   parameter bit XOR_IS_ZERO = 1'b1,
   localparam int AW = $clog2(ARCH_REGS),
   localparam int PW = $clog2(PHYS_REGS),
   localparam int CW = $clog2(LANES + 1)
)(
   input  logic                clk,
   input  logic                rst,
   input  logic [LANES-1:0]    in_valid,
   input  logic [2*LANES-1:0]  in_op,
   input  logic [AW*LANES-1:0] in_src_a,
   input  logic [AW*LANES-1:0] in_src_b,
   input  logic [AW*LANES-1:0] in_dst,
   input  logic [CW-1:0]       fl_avail,
   input  logic [PW*LANES-1:0] fl_tags,
   output logic [CW-1:0]       fl_pop,
   output logic                grp_stall,
   output logic [LANES-1:0]    dispatch_valid,
   output logic [LANES-1:0]    complete_valid,
   output logic [PW*LANES-1:0] out_src_a_tag,
   output logic [PW*LANES-1:0] out_src_b_tag,
   output logic [PW*LANES-1:0] out_dst_tag,
   output logic [LANES-1:0]    out_dst_zero_rdy
);
   generate
      if (LANES < 1 || LANES > 8) begin : g_bad_lanes
         $error("zidiom_rename: LANES must be 1..8");
      end
      if ((1 << AW) != ARCH_REGS) begin : g_bad_arch
         $error("zidiom_rename: ARCH_REGS must be a power of two");
      end
      if (PHYS_REGS <= ARCH_REGS) begin : g_bad_phys
         $error("zidiom_rename: PHYS_REGS must exceed ARCH_REGS");
      end
   endgenerate

   zi_cls_t             cls [LANES];
   logic [LANES-1:0]    alloc_v;
   logic [LANES-1:0]    zero_v;
   logic [LANES-1:0]    elim_v;
   logic [LANES-1:0]    map_we;
   logic [PW*LANES-1:0] lane_tag;
   logic [CW-1:0]       need;
   logic                stall;

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         zi_detect #(.AW(AW), .XOR_EN(XOR_IS_ZERO)) u_det (
            .vld   (in_valid[g]),
            .op    (in_op[g*2 +: 2]),
            .src_a (in_src_a[g*AW +: AW]),
            .src_b (in_src_b[g*AW +: AW]),
            .cls   (cls[g])
         );
         assign alloc_v[g] = cls[g].alloc;
         assign zero_v[g]  = cls[g].zero;
         assign elim_v[g]  = cls[g].elim;
      end
   endgenerate

   zi_alloc #(.LANES(LANES), .PW(PW), .CW(CW)) u_alloc (
      .clk      (clk),
      .rst      (rst),
      .alloc    (alloc_v),
      .fl_avail (fl_avail),
      .fl_tags  (fl_tags),
      .lane_tag (lane_tag),
      .need     (need),
      .stall    (stall)
   );

   assign map_we = alloc_v & {LANES{!stall}};

   zi_maptable #(.LANES(LANES), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS),
                 .AW(AW), .PW(PW)) u_map (
      .clk     (clk),
      .rst     (rst),
      .we      (map_we),
      .dst     (in_dst),
      .new_tag (lane_tag),
      .src_a   (in_src_a),
      .src_b   (in_src_b),
      .tag_a   (out_src_a_tag),
      .tag_b   (out_src_b_tag)
   );

   always_comb begin
      grp_stall        = stall;
      fl_pop           = stall ? '0 : need;
      dispatch_valid   = in_valid & ~elim_v & {LANES{!stall}};
      complete_valid   = elim_v & {LANES{!stall}};
      out_dst_zero_rdy = zero_v & {LANES{!stall}};
      for (int i = 0; i < LANES; i++) begin
         out_dst_tag[i*PW +: PW] = alloc_v[i] ? lane_tag[i*PW +: PW] : '0;
      end
   end

   // R7
   stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      grp_stall |-> (dispatch_valid == '0 && complete_valid == '0 && fl_pop == '0));

   // R8
   pop_bound_chk: assert property (@(posedge clk) disable iff (rst)
      fl_pop <= fl_avail);

   // R1
   excl_route_chk: assert property (@(posedge clk) disable iff (rst)
      (dispatch_valid & complete_valid) == '0);

   // R4
   zero_done_chk: assert property (@(posedge clk) disable iff (rst)
      (out_dst_zero_rdy & ~complete_valid) == '0);

   // R9
   idle_lane_chk: assert property (@(posedge clk) disable iff (rst)
      ((dispatch_valid | complete_valid) & ~in_valid) == '0);
endmodule

// File: tb/sim_zidiom_rename.sv
module sim_zidiom_rename;
   localparam int LANES = 4;
   localparam int AW = 4;
   localparam int PW = 6;
   localparam int CW = 3;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic [LANES-1:0]    in_valid = '0;
   logic [2*LANES-1:0]  in_op = '0;
   logic [AW*LANES-1:0] in_src_a = '0;
   logic [AW*LANES-1:0] in_src_b = '0;
   logic [AW*LANES-1:0] in_dst = '0;
   logic [CW-1:0]       fl_avail = '0;
   logic [PW*LANES-1:0] fl_tags = '0;
   logic [CW-1:0]       fl_pop;
   logic                grp_stall;
   logic [LANES-1:0]    dispatch_valid, complete_valid, out_dst_zero_rdy;
   logic [PW*LANES-1:0] out_src_a_tag, out_src_b_tag, out_dst_tag;

   always #5 clk = ~clk;

   zidiom_rename u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
      .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
      .fl_avail(fl_avail), .fl_tags(fl_tags), .fl_pop(fl_pop),
      .grp_stall(grp_stall), .dispatch_valid(dispatch_valid),
      .complete_valid(complete_valid), .out_src_a_tag(out_src_a_tag),
      .out_src_b_tag(out_src_b_tag), .out_dst_tag(out_dst_tag),
      .out_dst_zero_rdy(out_dst_zero_rdy)
   );

   typedef struct {
      string req;
      int    stall;
      int    pop;
      int    dv[LANES];
      int    cv[LANES];
      int    zr[LANES];
      int    ta[LANES];
      int    tb[LANES];
      int    td[LANES];
   } exp_t;

   exp_t q[$];
   int   ref_map[16];
   int   base = 0;
   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;

   function automatic int tag_at(int k);
      return 16 + ((base + k) % 48);
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // driver: applies one group and pushes its expected result
   task automatic grp(input logic [3:0] v, input logic [7:0] ops,
                      input logic [15:0] sa, input logic [15:0] sb,
                      input logic [15:0] d, input int avail, input string req);
      exp_t e;
      int   lm[16];
      int   need, k;
      @(negedge clk);
      in_valid = v; in_op = ops; in_src_a = sa; in_src_b = sb; in_dst = d;
      fl_avail = CW'(avail);
      for (int s = 0; s < LANES; s++) fl_tags[s*PW +: PW] = PW'(tag_at(s));
      e.req = req;
      need = 0;
      for (int i = 0; i < LANES; i++)
         if (v[i] && ops[i*2 +: 2] != 2'b11) need++;
      e.stall = (need > avail) ? 1 : 0;
      e.pop = e.stall ? 0 : need;
      lm = ref_map;
      k = 0;
      for (int i = 0; i < LANES; i++) begin
         int op, a, b, dd, zero, nop, alc;
         op = int'(ops[i*2 +: 2]);
         a = int'(sa[i*4 +: 4]); b = int'(sb[i*4 +: 4]); dd = int'(d[i*4 +: 4]);
         zero = (v[i] && (op == 1 || op == 2) && a == b) ? 1 : 0;
         nop  = (v[i] && op == 3) ? 1 : 0;
         alc  = (v[i] && op != 3) ? 1 : 0;
         e.ta[i] = lm[a]; e.tb[i] = lm[b];
         if (e.stall != 0) begin
            e.dv[i] = 0; e.cv[i] = 0; e.zr[i] = 0; e.td[i] = 0;
         end else begin
            e.dv[i] = (v[i] && !(zero != 0 || nop != 0)) ? 1 : 0;
            e.cv[i] = (zero != 0 || nop != 0) ? 1 : 0;
            e.zr[i] = zero;
            e.td[i] = (alc != 0) ? tag_at(k) : 0;
            if (alc != 0) begin lm[dd] = e.td[i]; k++; end
         end
      end
      if (e.stall == 0) begin ref_map = lm; base = base + need; end
      q.push_back(e);
   endtask

   // monitor: pops the expected group and compares, away from the edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, "grp_stall", int'(grp_stall), e.stall);
            chk(e.req, "fl_pop", int'(fl_pop), e.pop);
            for (int i = 0; i < LANES; i++) begin
               chk(e.req, $sformatf("dispatch_valid[%0d]", i), int'(dispatch_valid[i]), e.dv[i]);
               chk(e.req, $sformatf("complete_valid[%0d]", i), int'(complete_valid[i]), e.cv[i]);
               chk(e.req, $sformatf("zero_rdy[%0d]", i), int'(out_dst_zero_rdy[i]), e.zr[i]);
               if (e.stall == 0) begin
                  chk(e.req, $sformatf("src_a_tag[%0d]", i), int'(out_src_a_tag[i*PW +: PW]), e.ta[i]);
                  chk(e.req, $sformatf("src_b_tag[%0d]", i), int'(out_src_b_tag[i*PW +: PW]), e.tb[i]);
                  chk(e.req, $sformatf("dst_tag[%0d]", i), int'(out_dst_tag[i*PW +: PW]), e.td[i]);
               end
            end
         end
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      for (int r = 0; r < 16; r++) ref_map[r] = r;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R9: idle group after reset
      grp(4'b0000, 8'h00, 16'h0000, 16'h0000, 16'h0000, 4, "R9");
      // R9 identity map; R10: SUB with different sources, ALU with equal sources
      grp(4'b0111, {2'b00, 2'b00, 2'b01, 2'b00}, 16'h0635, 16'h0649, 16'h0921, 4, "R10");
      // R1 SUB zero, R6 dependent reads it, R2 XOR zero, R3 NOP
      grp(4'b1111, {2'b11, 2'b10, 2'b00, 2'b01}, 16'h0377, 16'h0327, 16'h0A87, 4, "R6");
      // R5: four zeroing ops
      grp(4'b1111, {2'b10, 2'b01, 2'b10, 2'b01}, 16'hCBAD, 16'hCBAD, 16'h3210, 4, "R5");
      // R7: three writers, two tags
      grp(4'b0111, {2'b00, 2'b00, 2'b01, 2'b00}, 16'h0111, 16'h0122, 16'h0543, 2, "R7");
      // R7: map untouched by the stalled group
      grp(4'b0011, {2'b00, 2'b00, 2'b00, 2'b00}, 16'h0053, 16'h0044, 16'h00EE, 4, "R7");
      // R3: only NOPs, no tags available
      grp(4'b1111, 8'hFF, 16'h1234, 16'h5678, 16'h9ABC, 0, "R3");
      // R8: NOP between writers, slots skip it
      grp(4'b1011, {2'b00, 2'b00, 2'b11, 2'b01}, 16'h7066, 16'h8066, 16'h9F0C, 3, "R8");
      // R6: two writers of r4, later lane reads r4
      grp(4'b1111, {2'b10, 2'b00, 2'b00, 2'b01}, 16'h4412, 16'h4412, 16'h4D44, 4, "R6");
      // R4: plain ALU gets tag without zero flag; R2 XOR zero alongside
      grp(4'b0011, {2'b00, 2'b00, 2'b10, 2'b00}, 16'h0055, 16'h0056, 16'h0077, 2, "R4");

      lf = 32'hACE1_2345;
      for (int n = 0; n < 60; n++) begin
         logic [3:0]  v;
         logic [7:0]  o;
         logic [15:0] a, b, d;
         int          av;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         v = lf[3:0]; o = lf[11:4];
         a = lf[27:12]; d = lf[31:16];
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         b = lf[5] ? a : lf[21:6];
         av = int'(lf[24:22]) % 5;
         grp(v, o, a, b, d, av, "R8");
      end

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule